// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block is a timer unit with one shared 16-bit prescaler and two independent 32-bit down-counters. The prescaler counts down from its reload value and emits a one-clock tick each time it passes zero. This gives one tick every (reload+1) clocks. Each enabled counter steps down by one on every tick.

When a counter goes from zero to all ones, the timer pulses its own interrupt line for one clock. If automatic reload is selected, the counter takes its reload value instead of all ones.

Software reaches all state through a flat 32-bit register bus. A write takes effect on the clock edge where it is presented. Reads are combinational from the address.

Top module: `tick_dual_timer`

## Requirements
- R1: After reset the prescaler count and prescaler reload both read 0xFFFF. Timer 1 counter and reload read 0xFFFFFFFF. Timer 2 counter and reload read 0. Both control registers read 0, and both interrupt outputs are low.
- R2: The prescaler count steps down by one each clock. In the cycle where it is zero it issues a tick and reloads, so the count repeats reload, reload-1, ..., 0 with a period of reload+1 clocks.
- R3: A write to offset 0x64 stores the low 16 bits of the data as the prescaler reload and also restarts the count from that value. Offset 0x60 reads the current count and offset 0x64 reads the reload, with the upper 16 bits zero.
- R4: A timer whose control bit 0 (enable) is set decrements its counter by one on each prescaler tick. A timer with enable clear holds its counter.
- R5: When an enabled timer's counter is zero at a tick, the counter becomes all ones. The timer's interrupt output goes high for exactly the following clock. irq_o bit 0 belongs to timer 1 (interrupt number 8) and bit 1 to timer 2 (interrupt number 9).
- R6: If control bit 1 (auto-reload) is set, an underflow loads the counter from its reload register instead of all ones, and the interrupt still fires.
- R7: Writing a control value with bit 2 set loads the counter from the reload register at that edge. Control reads back only bits 3, 1 and 0 as written; bit 2 and all higher bits read 0.
- R8: Writes to a counter or reload register take effect at the write edge. A counter write overrides a decrement, reload or interrupt due in the same cycle.
- R9: The timer registers sit at 0x40/0x44/0x48 (timer 1 counter, reload, control) and 0x50/0x54/0x58 (timer 2). Reads of any offset not in the map return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted clock |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 2 | One-clock interrupt pulses, bit k for timer k+1 |

## Verification
The assertions assume that at most one register is written per clock. They also assume the prescaler count never exceeds its reload, which holds because a reload write restarts the count as well.

The directed stimulus issues a single write per cycle from a task that always returns on a falling edge. This lets back-to-back writes hit consecutive edges, including a counter write landing exactly on an underflow edge.

Timer tests run with a prescaler reload of zero, so a tick occurs every clock and each counter step lands on a known edge.

// File: rtl/dtmr_pkg.sv
// Package dtmr_pkg: register offsets and control-bit positions shared by the
// timer unit. Assumes byte offsets on an 8-bit address and 32-bit data.
package dtmr_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] OFS_PRE_CNT  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_PRE_RLD  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_TMR_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_TMR_STEP = 8'h10;
    localparam logic [ADDR_W-1:0] SUB_CNT      = 8'h00;
    localparam logic [ADDR_W-1:0] SUB_RLD      = 8'h04;
    localparam logic [ADDR_W-1:0] SUB_CTL      = 8'h08;

    // control word bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_AUTO  = 1;
    localparam int CB_LOAD  = 2;
    localparam int CB_SPARE = 3;

    typedef struct packed {
        logic spare;
        logic auto_rl;
        logic run;
    } tmr_ctl_t;
endpackage

// File: rtl/dtmr_prescaler.sv
// dtmr_prescaler: shared down-counting prescaler. It ticks for one clock when
// the count is zero and then reloads, so it ticks every (reload+1) clocks.
// A reload write restarts the count from the written value.
// Assumes a synchronous active-low reset.
module dtmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_wr,
    input  logic [PRE_W-1:0] rld_wdata,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] rld_o,
    output logic             tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] rld_q;

    // count down, reload at zero, restart on reload write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            rld_q <= '1;
        end else if (rld_wr) begin
            cnt_q <= rld_wdata;
            rld_q <= rld_wdata;
        end else if (cnt_q == '0) begin
            cnt_q <= rld_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // tick marks the last count of each period
    always_comb tick_o = (cnt_q == '0);

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;

    assert_tick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !rld_wr) |=> (cnt_q == $past(rld_q)));
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !rld_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_rld_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rld_wr |=> (rld_q == $past(rld_wdata)) && (cnt_q == $past(rld_wdata)));
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= rld_q);
endmodule

// File: rtl/dtmr_channel.sv
// dtmr_channel: one down-counting timer with counter, reload and control
// registers. It decrements on prescaler ticks when enabled and pulses irq_o
// for one clock after an underflow. A counter write beats any update in the
// same cycle. Assumes at most one of its write strobes is high per clock.
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int   CNT_W    = 32,
    parameter logic INIT_SET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr,
    input  logic             rld_wr,
    input  logic             ctl_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [3:0]       ctl_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] INIT_VAL = INIT_SET ? '1 : '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    tmr_ctl_t         ctl_q;
    logic             irq_q;
    logic             load_now;
    logic             step;
    logic             fire;

    // decode the immediate-load request and the underflow event
    always_comb begin
        load_now = ctl_wr && wdata[CB_LOAD];
        step     = tick_i && ctl_q.run;
        fire     = step && (cnt_q == '0) && !cnt_wr && !load_now;
    end

    // counter: write, immediate load, then tick-driven decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= INIT_VAL;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (load_now) begin
            cnt_q <= rld_q;
        end else if (step) begin
            if ((cnt_q == '0) && ctl_q.auto_rl) cnt_q <= rld_q;
            else                                cnt_q <= cnt_q - 1'b1;
        end
    end

    // reload register
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= INIT_VAL;
        else if (rld_wr) rld_q <= wdata;
    end

    // control register keeps only enable, auto-reload and spare bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.spare   <= wdata[CB_SPARE];
            ctl_q.auto_rl <= wdata[CB_AUTO];
            ctl_q.run     <= wdata[CB_RUN];
        end
    end

    // registered single-clock interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = {ctl_q.spare, 1'b0, ctl_q.auto_rl, ctl_q.run};
    assign irq_o = irq_q;

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctl_q.run && !cnt_wr && !load_now && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !cnt_wr && !load_now) |=> $stable(cnt_q));
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cnt_q) == '0) && $past(ctl_q.run) && $past(tick_i));
    assert_underflow_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctl_q.run && !ctl_q.auto_rl && cnt_q == '0 && !cnt_wr && !load_now)
        |=> (cnt_q == '1) && irq_o);
    assert_autoreload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctl_q.run && ctl_q.auto_rl && cnt_q == '0 && !cnt_wr && !load_now)
        |=> (cnt_q == $past(rld_q)) && irq_o);
    assert_load_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[CB_LOAD] && !cnt_wr) |=> (cnt_q == $past(rld_q)));
    assert_cnt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata)) && !irq_o);
endmodule

// File: rtl/tick_dual_timer.sv
// tick_dual_timer: prescaler plus NUM_TMR timer channels behind a flat
// register bus. It decodes one write per clock and multiplexes reads
// combinationally. Channel k sits at OFS_TMR_BASE + k*OFS_TMR_STEP; the
// defaults keep this clear of the prescaler registers.
// Channel 0 resets to all ones, the others to zero.
module tick_dual_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] irq_o
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_rld;
    logic             pre_tick;
    logic             pre_rld_wr;

    logic [CNT_W-1:0] t_cnt [NUM_TMR];
    logic [CNT_W-1:0] t_rld [NUM_TMR];
    logic [3:0]       t_ctl [NUM_TMR];
    logic [NUM_TMR-1:0] t_cnt_wr, t_rld_wr, t_ctl_wr;

    // prescaler reload strobe
    always_comb pre_rld_wr = bus_wr && (bus_addr == OFS_PRE_RLD);

    dtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .rld_wr    (pre_rld_wr),
        .rld_wdata (bus_wdata[PRE_W-1:0]),
        .cnt_o     (pre_cnt),
        .rld_o     (pre_rld),
        .tick_o    (pre_tick)
    );

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        localparam logic [ADDR_W-1:0] BASE = OFS_TMR_BASE + ADDR_W'(k) * OFS_TMR_STEP;

        // per-channel write strobes
        always_comb begin
            t_cnt_wr[k] = bus_wr && (bus_addr == BASE + SUB_CNT);
            t_rld_wr[k] = bus_wr && (bus_addr == BASE + SUB_RLD);
            t_ctl_wr[k] = bus_wr && (bus_addr == BASE + SUB_CTL);
        end

        dtmr_channel #(
            .CNT_W    (CNT_W),
            .INIT_SET ((k == 0) ? 1'b1 : 1'b0)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (pre_tick),
            .cnt_wr (t_cnt_wr[k]),
            .rld_wr (t_rld_wr[k]),
            .ctl_wr (t_ctl_wr[k]),
            .wdata  (bus_wdata[CNT_W-1:0]),
            .cnt_o  (t_cnt[k]),
            .rld_o  (t_rld[k]),
            .ctl_o  (t_ctl[k]),
            .irq_o  (irq_o[k])
        );
    end

    // read multiplexer, unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_PRE_CNT) bus_rdata = DATA_W'(pre_cnt);
        if (bus_addr == OFS_PRE_RLD) bus_rdata = DATA_W'(pre_rld);
        for (int k = 0; k < NUM_TMR; k++) begin
            if (bus_addr == OFS_TMR_BASE + ADDR_W'(k) * OFS_TMR_STEP + SUB_CNT)
                bus_rdata = DATA_W'(t_cnt[k]);
            if (bus_addr == OFS_TMR_BASE + ADDR_W'(k) * OFS_TMR_STEP + SUB_RLD)
                bus_rdata = DATA_W'(t_rld[k]);
            if (bus_addr == OFS_TMR_BASE + ADDR_W'(k) * OFS_TMR_STEP + SUB_CTL)
                bus_rdata = DATA_W'(t_ctl[k]);
        end
    end

    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({t_cnt_wr, t_rld_wr, t_ctl_wr, pre_rld_wr}) <= 1);
    assert_irq_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/tick_dual_timer_tb_top.sv
// Directed bench for tick_dual_timer. Every task starts and ends on a
// falling edge, so writes issued back to back land on consecutive edges.
module tick_dual_timer_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    tick_dual_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h60, v); chk("R1 pre count", v, 32'h0000FFFF);
        rd(8'h64, v); chk("R1 pre reload", v, 32'h0000FFFF);
        rd(8'h40, v); chk("R1 t1 count", v, 32'hFFFFFFFF);
        rd(8'h44, v); chk("R1 t1 reload", v, 32'hFFFFFFFF);
        rd(8'h48, v); chk("R1 t1 ctl", v, 32'h0);
        rd(8'h50, v); chk("R1 t2 count", v, 32'h0);
        rd(8'h54, v); chk("R1 t2 reload", v, 32'h0);
        rd(8'h58, v); chk("R1 t2 ctl", v, 32'h0);
        chk("R1 irq", {30'b0, irq_o}, 32'h0);
    endtask

    task automatic t_prescaler;
        logic [31:0] v;
        wr(8'h64, 32'd3);
        rd(8'h60, v); chk("R3 restart", v, 32'd3);
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            rd(8'h60, v); chk("R2 period", v, 32'(3 - (i % 4)));
        end
        rd(8'h64, v); chk("R3 reload read", v, 32'd3);
        wr(8'h64, 32'h00012345);
        rd(8'h64, v); chk("R3 truncate", v, 32'h00002345);
        wr(8'h64, 32'd0);
        rd(8'h64, v); chk("R3 zero reload", v, 32'd0);
    endtask

    task automatic t_underflow;
        logic [31:0] v;
        wr(8'h40, 32'd5);
        wr(8'h48, 32'd1);
        rd(8'h40, v); chk("R4 start", v, 32'd5);
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            rd(8'h40, v); chk("R4 R5 count", v, 32'd5 - 32'(i));
            chk("R5 irq pulse", {30'b0, irq_o}, (i == 6) ? 32'd1 : 32'd0);
        end
        wr(8'h48, 32'd0);
        rd(8'h40, v);
        repeat (3) @(negedge clk);
        begin
            logic [31:0] w;
            rd(8'h40, w); chk("R4 hold", w, v);
        end
    endtask

    task automatic t_autoreload;
        logic [31:0] v;
        logic [31:0] exp_c [6] = '{32'd0, 32'd2, 32'd1, 32'd0, 32'd2, 32'd1};
        wr(8'h54, 32'd2);
        wr(8'h50, 32'd1);
        wr(8'h58, 32'd3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd(8'h50, v); chk("R6 count", v, exp_c[i]);
            chk("R6 irq", {30'b0, irq_o}, (i == 1 || i == 4) ? 32'd2 : 32'd0);
        end
        wr(8'h58, 32'd0);
    endtask

    task automatic t_ctl;
        logic [31:0] v;
        wr(8'h44, 32'h1234);
        wr(8'h48, 32'hC);
        rd(8'h40, v); chk("R7 load now", v, 32'h1234);
        rd(8'h48, v); chk("R7 ctl read", v, 32'h8);
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h48, v); chk("R7 ctl mask", v, 32'hB);
        rd(8'h40, v); chk("R7 load all", v, 32'h1234);
        wr(8'h48, 32'd0);
    endtask

    task automatic t_override;
        logic [31:0] v;
        wr(8'h48, 32'd1);
        wr(8'h40, 32'd0);
        wr(8'h40, 32'd7);
        rd(8'h40, v); chk("R8 count wins", v, 32'd7);
        chk("R8 no irq", {30'b0, irq_o}, 32'd0);
        wr(8'h48, 32'd0);
        wr(8'h44, 32'h55);
        rd(8'h44, v); chk("R8 reload write", v, 32'h55);
    endtask

    task automatic t_map;
        logic [31:0] v;
        rd(8'h00, v); chk("R9 unmapped 00", v, 32'h0);
        rd(8'h68, v); chk("R9 unmapped 68", v, 32'h0);
        rd(8'h4C, v); chk("R9 unmapped 4C", v, 32'h0);
        rd(8'h58, v); chk("R9 t2 ctl", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescaler();
        t_underflow();
        t_autoreload();
        t_ctl();
        t_override();
        t_map();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule